// File: doc/BRIEF.md
# Set-Associative Branch Target Buffer

This block sits at the head of an instruction fetch pipe and picks the next fetch address for each 16-byte fetch line. The fetch address is cut into an offset within the line, a set index and a tag. The block reads every way of the indexed set and keeps the ways whose tag matches and whose branch lies at or after the fetch offset. Among those, the branch with the lowest offset that is predicted taken supplies the target. If none is taken, fetch continues at the start of the next line.

Conditional branches are predicted by a two-level scheme. Each entry keeps its own short local history. That history selects one of a bank of saturating two-bit counters, and each set owns its own bank. The history is advanced speculatively with the predicted outcome as soon as a prediction is made. When the branch resolves, the update port repairs the history from the value it had at prediction time and trains the counter. A taken branch that is not yet in the table is written into the way named by a per-set round-robin pointer.

Top module: `btb_fetch_predictor`

## Requirements
- R1: When no eligible hit is predicted taken, `pred_taken` is 0 and `pred_next_pc` is the fetch address with its low 4 bits cleared plus 16.
- R2: A way hits only if it is valid and its stored tag equals fetch address bits [31:11] in the set selected by bits [10:4]. Bits [3:0] are the offset within the line.
- R3: A hitting branch whose stored offset is below the fetch offset takes no part in the prediction.
- R4: Among eligible hits predicted taken, the one with the lowest offset is chosen, whatever way holds it. Its stored target is driven on `pred_next_pc` with `pred_taken` = 1.
- R5: A conditional branch is predicted taken when bit 1 of the counter is set. The counter is the one indexed by the branch's 4-bit history, taken from the 16-counter bank of its set. Counters reset to 01.
- R6: The branch type is encoded as 00 conditional, 01 return, 10 call and 11 unconditional. Types other than 00 are always predicted taken, and the chosen type appears on `pred_type`.
- R7: On a valid fetch, each eligible conditional branch up to and including the chosen offset has its history shifted left. The chosen branch shifts in 1 and the others shift in 0. `pred_hist` shows the chosen branch's history from before the shift, or 0 when nothing is taken.
- R8: A resolve (`upd_valid`) moves the counter at index `upd_hist` of the branch's set up on taken and down on not taken, saturating at 0 and 3. On a hit, it sets the entry's history to `{upd_hist[2:0], upd_taken}`, and this write wins over a speculative write to the same entry.
- R9: A taken resolve that misses writes a valid entry into the way named by the set's 2-bit pointer, with history 0001. The pointer then advances by one, modulo 4. A not-taken miss creates no entry.
- R10: After reset all entries are invalid, every pointer is 0 and every counter is 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | A fetch is made this cycle (enables the speculative history update) |
| fetch_pc | input | 32 | Fetch address |
| pred_taken | output | 1 | A taken branch was found in the line |
| pred_type | output | 2 | Type of the chosen branch |
| pred_next_pc | output | 32 | Predicted next fetch address |
| pred_hist | output | 4 | History of the chosen branch before this prediction |
| upd_valid | input | 1 | A branch resolves this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual direction |
| upd_type | input | 2 | Type of the resolved branch, used on allocation |
| upd_target | input | 32 | Actual target |
| upd_hist | input | 4 | History the branch had when it was predicted |

## Verification
The assertions take for granted that `upd_hist` returns the history the predictor handed out for that branch. They also assume that a branch address is never allocated twice, since allocation happens only after a missing lookup. The check on the speculative bit holds only in cycles with no resolve, because a resolve to the same entry takes priority. The stimulus therefore drives fetches and resolves in separate cycles. It trains counters only through the update port, using history values chosen so that the resulting history and counter state are known exactly.

// File: rtl/btb_fetch_pkg.sv
`timescale 1ns/1ps
package btb_fetch_pkg;
   typedef enum logic [1:0] {
      BR_COND = 2'b00,
      BR_RET  = 2'b01,
      BR_CALL = 2'b10,
      BR_JUMP = 2'b11
   } br_kind_e;

   typedef logic [1:0] ctr_t;
   localparam ctr_t CTR_INIT = 2'b01;
   localparam ctr_t CTR_MAX  = 2'b11;
endpackage

// File: rtl/btb_way_pick.sv
`timescale 1ns/1ps
module btb_way_pick #(
   parameter int WAYS  = 4,
   parameter int OFF_W = 4
) (
   input  logic [WAYS-1:0]            hit,
   input  logic [WAYS-1:0][OFF_W-1:0] off,
   input  logic [WAYS-1:0]            taken,
   input  logic [OFF_W-1:0]           fetch_off,
   output logic [WAYS-1:0]            sel,
   output logic                       found,
   output logic [WAYS-1:0]            seen
);
   logic [WAYS-1:0]  elig;
   logic [WAYS-1:0]  cand;
   logic [OFF_W-1:0] sel_off;

   always_comb begin
      for (int i = 0; i < WAYS; i++) begin
         elig[i] = hit[i] && (off[i] >= fetch_off);
         cand[i] = elig[i] && taken[i];
      end
      for (int i = 0; i < WAYS; i++) begin
         sel[i] = cand[i];
         for (int j = 0; j < WAYS; j++) begin
            if (j != i && cand[j] && ((off[j] < off[i]) || (off[j] == off[i] && j < i)))
               sel[i] = 1'b0;
         end
      end
      found   = |cand;
      sel_off = '0;
      for (int i = 0; i < WAYS; i++)
         if (sel[i]) sel_off = sel_off | off[i];
      for (int i = 0; i < WAYS; i++)
         seen[i] = elig[i] && (!found || off[i] <= sel_off);
   end
endmodule

// File: rtl/btb_dir_table.sv
`timescale 1ns/1ps
module btb_dir_table
   import btb_fetch_pkg::*;
#(
   parameter int SETS   = 128,
   parameter int HIST_W = 4,
   parameter int WAYS   = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [$clog2(SETS)-1:0]        rd_set,
   input  logic [WAYS-1:0][HIST_W-1:0]    rd_hist,
   output logic [WAYS-1:0]                rd_taken,
   input  logic                           wr_en,
   input  logic [$clog2(SETS)-1:0]        wr_set,
   input  logic [HIST_W-1:0]              wr_idx,
   input  logic                           wr_taken
);
   localparam int CTRS = 1 << HIST_W;

   ctr_t ctr_q [SETS][CTRS];
   ctr_t cur;

   always_comb cur = ctr_q[wr_set][wr_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++)
            for (int c = 0; c < CTRS; c++)
               ctr_q[s][c] <= CTR_INIT;
      end else if (wr_en) begin
         if (wr_taken && cur != CTR_MAX)
            ctr_q[wr_set][wr_idx] <= cur + 2'd1;
         else if (!wr_taken && cur != 2'd0)
            ctr_q[wr_set][wr_idx] <= cur - 2'd1;
      end
   end

   for (genvar w = 0; w < WAYS; w++) begin : g_rd
      assign rd_taken[w] = ctr_q[rd_set][rd_hist[w]][1];
   end

   // R8: counters stick at both ends
   a_r8_sat_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_taken && cur == CTR_MAX) |=> (ctr_q[$past(wr_set)][$past(wr_idx)] == CTR_MAX));
   a_r8_sat_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_taken && cur == 2'd0) |=> (ctr_q[$past(wr_set)][$past(wr_idx)] == 2'd0));
endmodule

// File: rtl/btb_fetch_predictor.sv
`timescale 1ns/1ps
module btb_fetch_predictor
   import btb_fetch_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int SETS       = 128,
   parameter int WAYS       = 4,
   parameter int LINE_BYTES = 16,
   parameter int HIST_W     = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fetch_valid,
   input  logic [ADDR_W-1:0]   fetch_pc,
   output logic                pred_taken,
   output logic [1:0]          pred_type,
   output logic [ADDR_W-1:0]   pred_next_pc,
   output logic [HIST_W-1:0]   pred_hist,
   input  logic                upd_valid,
   input  logic [ADDR_W-1:0]   upd_pc,
   input  logic                upd_taken,
   input  logic [1:0]          upd_type,
   input  logic [ADDR_W-1:0]   upd_target,
   input  logic [HIST_W-1:0]   upd_hist
);
   localparam int OFF_W  = $clog2(LINE_BYTES);
   localparam int IDX_W  = $clog2(SETS);
   localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
   localparam int WAY_W  = $clog2(WAYS);
   localparam int LINE_W = ADDR_W - OFF_W;
   localparam logic [LINE_W-1:0] LINE_ONE = LINE_W'(1);
   localparam logic [HIST_W-1:0] HIST_NEW = HIST_W'(1);

   if (LINE_BYTES != (1 << OFF_W)) begin : g_chk_line
      $error("LINE_BYTES must be a power of two");
   end
   if (SETS != (1 << IDX_W)) begin : g_chk_sets
      $error("SETS must be a power of two");
   end
   if (WAYS < 2 || WAYS != (1 << WAY_W)) begin : g_chk_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (HIST_W < 2) begin : g_chk_hist
      $error("HIST_W must be at least 2");
   end

   // entry storage
   logic                vld_q  [SETS][WAYS];
   logic [WAY_W-1:0]    ptr_q  [SETS];
   logic [TAG_W-1:0]    tag_q  [SETS][WAYS];
   logic [OFF_W-1:0]    off_q  [SETS][WAYS];
   br_kind_e            kind_q [SETS][WAYS];
   logic [ADDR_W-1:0]   tgt_q  [SETS][WAYS];
   logic [HIST_W-1:0]   hist_q [SETS][WAYS];

   // lookup side
   logic [IDX_W-1:0] f_set;
   logic [TAG_W-1:0] f_tag;
   logic [OFF_W-1:0] f_off;
   assign f_set = fetch_pc[OFF_W +: IDX_W];
   assign f_tag = fetch_pc[ADDR_W-1 -: TAG_W];
   assign f_off = fetch_pc[OFF_W-1:0];

   logic [WAYS-1:0]              f_hit, dir_taken, way_taken, sel, seen;
   logic [WAYS-1:0][OFF_W-1:0]   f_offs;
   logic [WAYS-1:0][HIST_W-1:0]  f_hist;
   br_kind_e                     f_kind [WAYS];
   logic                         found;

   always_comb begin
      for (int w = 0; w < WAYS; w++) begin
         f_hit[w]     = vld_q[f_set][w] && (tag_q[f_set][w] == f_tag);
         f_offs[w]    = off_q[f_set][w];
         f_hist[w]    = hist_q[f_set][w];
         f_kind[w]    = kind_q[f_set][w];
         way_taken[w] = (f_kind[w] != BR_COND) || dir_taken[w];
      end
   end

   btb_dir_table #(.SETS(SETS), .HIST_W(HIST_W), .WAYS(WAYS)) u_dir (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_set   (f_set),
      .rd_hist  (f_hist),
      .rd_taken (dir_taken),
      .wr_en    (upd_valid),
      .wr_set   (upd_pc[OFF_W +: IDX_W]),
      .wr_idx   (upd_hist),
      .wr_taken (upd_taken)
   );

   btb_way_pick #(.WAYS(WAYS), .OFF_W(OFF_W)) u_pick (
      .hit       (f_hit),
      .off       (f_offs),
      .taken     (way_taken),
      .fetch_off (f_off),
      .sel       (sel),
      .found     (found),
      .seen      (seen)
   );

   logic [ADDR_W-1:0] c_tgt;
   logic [1:0]        c_kind;
   logic [HIST_W-1:0] c_hist;
   logic [OFF_W-1:0]  c_off;
   logic [WAY_W-1:0]  sel_way;
   always_comb begin
      c_tgt = '0; c_kind = '0; c_hist = '0; c_off = '0; sel_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (sel[w]) begin
            c_tgt   = c_tgt  | tgt_q[f_set][w];
            c_kind  = c_kind | f_kind[w];
            c_hist  = c_hist | f_hist[w];
            c_off   = c_off  | f_offs[w];
            sel_way = WAY_W'(w);
         end
      end
   end

   assign pred_taken   = found;
   assign pred_type    = c_kind;
   assign pred_hist    = c_hist;
   assign pred_next_pc = found ? c_tgt : {fetch_pc[ADDR_W-1:OFF_W] + LINE_ONE, {OFF_W{1'b0}}};

   // resolve side
   logic [IDX_W-1:0] u_set;
   logic [TAG_W-1:0] u_tag;
   logic [OFF_W-1:0] u_off;
   logic             u_hit_any, alloc;
   logic [WAY_W-1:0] u_way, a_way;
   assign u_set = upd_pc[OFF_W +: IDX_W];
   assign u_tag = upd_pc[ADDR_W-1 -: TAG_W];
   assign u_off = upd_pc[OFF_W-1:0];

   always_comb begin
      u_hit_any = 1'b0;
      u_way     = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (vld_q[u_set][w] && tag_q[u_set][w] == u_tag && off_q[u_set][w] == u_off) begin
            u_hit_any = 1'b1;
            u_way     = WAY_W'(w);
         end
      end
   end
   assign a_way = ptr_q[u_set];
   assign alloc = upd_valid && upd_taken && !u_hit_any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            ptr_q[s] <= '0;
            for (int w = 0; w < WAYS; w++) vld_q[s][w] <= 1'b0;
         end
      end else if (alloc) begin
         vld_q[u_set][a_way] <= 1'b1;
         ptr_q[u_set]        <= a_way + WAY_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (fetch_valid) begin
         for (int w = 0; w < WAYS; w++)
            if (seen[w] && f_kind[w] == BR_COND)
               hist_q[f_set][w] <= {f_hist[w][HIST_W-2:0], sel[w]};
      end
      if (upd_valid && u_hit_any) begin
         hist_q[u_set][u_way] <= {upd_hist[HIST_W-2:0], upd_taken};
         if (upd_taken) tgt_q[u_set][u_way] <= upd_target;
      end else if (alloc) begin
         tag_q[u_set][a_way]  <= u_tag;
         off_q[u_set][a_way]  <= u_off;
         kind_q[u_set][a_way] <= br_kind_e'(upd_type);
         tgt_q[u_set][a_way]  <= upd_target;
         hist_q[u_set][a_way] <= HIST_NEW;
      end
   end

   a_r1_line_start: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && !pred_taken) |-> (pred_next_pc[OFF_W-1:0] == '0));
   a_r3_not_behind: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && pred_taken) |-> (c_off >= f_off));
   a_r4_single_pick: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel) && (found == (|sel)));
   a_r7_spec_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && pred_taken && pred_type == BR_COND && !upd_valid)
      |=> hist_q[$past(f_set)][$past(sel_way)][0]);
   a_r9_alloc_valid: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |=> vld_q[$past(u_set)][$past(a_way)]);
endmodule

// File: tb/btb_fetch_predictor_bench.sv
`timescale 1ns/1ps
module btb_fetch_predictor_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_valid = 1'b0;
   logic [31:0] fetch_pc = '0;
   logic        pred_taken;
   logic [1:0]  pred_type;
   logic [31:0] pred_next_pc;
   logic [3:0]  pred_hist;
   logic        upd_valid = 1'b0;
   logic [31:0] upd_pc = '0;
   logic        upd_taken = 1'b0;
   logic [1:0]  upd_type = '0;
   logic [31:0] upd_target = '0;
   logic [3:0]  upd_hist = '0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic        taken;
      logic [31:0] next;
      logic [1:0]  kind;
      logic [3:0]  hist;
      string       req;
   } exp_t;
   exp_t sb[$];

   always #2.5 clk = ~clk;

   btb_fetch_predictor u_btb_fetch_predictor (
      .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
      .pred_taken(pred_taken), .pred_type(pred_type), .pred_next_pc(pred_next_pc),
      .pred_hist(pred_hist), .upd_valid(upd_valid), .upd_pc(upd_pc),
      .upd_taken(upd_taken), .upd_type(upd_type), .upd_target(upd_target),
      .upd_hist(upd_hist)
   );

   task automatic fetch(input logic [31:0] pc, input logic tk, input logic [31:0] nxt,
                        input logic [1:0] kd, input logic [3:0] hs, input string req);
      exp_t e;
      @(negedge clk);
      fetch_valid = 1'b1;
      fetch_pc    = pc;
      e.taken = tk; e.next = nxt; e.kind = kd; e.hist = hs; e.req = req;
      sb.push_back(e);
      @(negedge clk);
      fetch_valid = 1'b0;
   endtask

   task automatic resolve(input logic [31:0] pc, input logic tk, input logic [1:0] kd,
                          input logic [31:0] tgt, input logic [3:0] hs);
      @(negedge clk);
      upd_valid = 1'b1; upd_pc = pc; upd_taken = tk;
      upd_type = kd; upd_target = tgt; upd_hist = hs;
      @(negedge clk);
      upd_valid = 1'b0;
   endtask

   // monitor: compares each fetch result against the queued expectation
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (fetch_valid && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (pred_taken !== e.taken || pred_next_pc !== e.next || pred_hist !== e.hist ||
                (e.taken && pred_type !== e.kind)) begin
               errors++;
               $display("FAIL %s pc=%h: got taken=%0b next=%h type=%b hist=%b, expected taken=%0b next=%h type=%b hist=%b",
                        e.req, fetch_pc, pred_taken, pred_next_pc, pred_type, pred_hist,
                        e.taken, e.next, e.kind, e.hist);
            end
         end
      end
   end

   initial begin
      #1000000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   localparam logic [1:0] K_C = 2'b00, K_R = 2'b01, K_L = 2'b10, K_J = 2'b11;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10: reset state seen at the outputs
      fetch_pc = 32'h0000_1230;
      #1;
      checks++;
      if (pred_taken !== 1'b0 || pred_hist !== 4'b0 || pred_next_pc !== 32'h0000_1240) begin
         errors++;
         $display("FAIL R10 reset: taken=%0b hist=%b next=%h, expected 0 0000 00001240",
                  pred_taken, pred_hist, pred_next_pc);
      end
      fetch(32'h1230, 0, 32'h1240, K_C, 4'b0000, "R1 empty table falls through");

      // R9 allocate conditional C at offset 2, then train counters (R8)
      resolve(32'h1232, 1, K_C, 32'h9000, 4'b0000);
      resolve(32'h1232, 1, K_C, 32'h9000, 4'b0100);
      resolve(32'h1232, 1, K_C, 32'h9000, 4'b0100);
      resolve(32'h1232, 1, K_C, 32'h9000, 4'b0100);  // R8 saturate high
      resolve(32'h1232, 0, K_C, 32'h9000, 4'b0001);  // history -> 0010
      fetch(32'h1230, 0, 32'h1240, K_C, 4'b0000, "R5 weak counter predicts not taken");
      fetch(32'h1230, 1, 32'h9000, K_C, 4'b0100, "R7 speculative shift selects strong counter");
      fetch(32'h1230, 0, 32'h1240, K_C, 4'b0000, "R7 speculative shift after taken");
      resolve(32'h1232, 0, K_C, 32'h9000, 4'b0010);  // repair history to 0100
      fetch(32'h1230, 1, 32'h9000, K_C, 4'b0100, "R8 repaired history and saturated counter");
      resolve(32'h1232, 0, K_C, 32'h9000, 4'b0010);  // R8 saturate low
      resolve(32'h1232, 1, K_C, 32'h9000, 4'b0010);
      resolve(32'h1232, 1, K_C, 32'h9000, 4'b0010);
      resolve(32'h1232, 0, K_C, 32'h9000, 4'b1001);  // history -> 0010
      fetch(32'h1230, 1, 32'h9000, K_C, 4'b0010, "R8 low saturation then two increments");

      // R6 unconditional at offset 4 in way 1
      resolve(32'h1234, 1, K_J, 32'h8000, 4'b0000);
      fetch(32'h1230, 1, 32'h8000, K_J, 4'b0001, "R6 jump taken with counter at zero");
      fetch(32'h1238, 0, 32'h1240, K_C, 4'b0000, "R3 all hits behind fetch offset");
      fetch(32'h1233, 1, 32'h8000, K_J, 4'b0001, "R3 earlier branch skipped");

      // R4 call at offset 1 lands in way 2
      resolve(32'h1231, 1, K_L, 32'hA000, 4'b0000);
      fetch(32'h1230, 1, 32'hA000, K_L, 4'b0001, "R4 lowest offset wins over lower way");

      // R9 return in way 3, then a fifth branch wraps the pointer to way 0
      resolve(32'h1237, 1, K_R, 32'hB000, 4'b0000);
      resolve(32'h1239, 1, K_J, 32'hC000, 4'b0000);
      fetch(32'h1236, 1, 32'hB000, K_R, 4'b0001, "R6 return predicted taken");
      fetch(32'h1238, 1, 32'hC000, K_J, 4'b0001, "R9 fifth branch allocated");
      fetch(32'h1232, 1, 32'h8000, K_J, 4'b0001, "R9 replacement took way 0");
      fetch(32'h1231, 1, 32'hA000, K_L, 4'b0001, "R9 way 2 kept");

      // R2 tag and set selection
      fetch(32'h3230, 0, 32'h3240, K_C, 4'b0000, "R2 same set other tag misses");
      fetch(32'h1240, 0, 32'h1250, K_C, 4'b0000, "R2 other set misses");

      // R9 not-taken miss does not allocate
      resolve(32'h1250, 0, K_C, 32'hD000, 4'b0000);
      resolve(32'h1250, 0, K_C, 32'hD000, 4'b0000);
      fetch(32'h1250, 0, 32'h1260, K_C, 4'b0000, "R9 not-taken miss left no entry");

      @(negedge clk);
      #2;
      checks++;
      if (sb.size() != 0) begin
         errors++;
         $display("FAIL R1 scoreboard left %0d items, expected 0", sb.size());
      end
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule